// File: doc/BRIEF.md
# Protected Module Memory Access Controller

This block sits beside the fetch and load/store paths of a 16-bit microcontroller. It keeps a few software modules apart from the rest of the code and from each other. Each protected module owns a code region and a data region. Each region is a half-open address span. When a module is enabled it is given an ID equal to its slot number plus one, so the first ID is 1. Code that lies outside every protected module runs with ID 0.

Every cycle the block maps the program counter to a protection domain and tracks two IDs: the one now executing, and the one that executed before the most recent domain change. It checks every data access and every domain entry against the live modules. Any breach gives a one-cycle violation pulse. It also sets an interrupt flag, which stays up until the end of the instruction in progress.

Enabling a module does not make it live at once. The block first walks the new module's data region and issues one clear write per cycle. The module is protected only after that walk ends. The block does not write memory itself. It drives the clear request and leaves the write to the memory.

Top module: `pmac_top`

## Requirements
- R1: After reset, `cur_id_o` and `caller_id_o` are 0, and `viol_o`, `viol_irq_o` and `clr_we_o` are low.
- R2: A region spans from its low bound (inclusive) to its high bound (exclusive). A region whose low bound is not below its high bound is empty and matches no address.
- R3: Slot k holds ID k+1. An enable takes the lowest free slot. One cycle after the program counter enters a live module's code region, `cur_id_o` shows that module's ID. Outside every live module it shows 0.
- R4: `caller_id_o` changes only when the domain of the program counter differs from `cur_id_o`. It then takes the old `cur_id_o` value.
- R5: A write to the code region of any live module is a violation, even when that module itself is running. A read of a code region is not.
- R6: Any access to a live module's data region is a violation unless the program counter lies in that module's code region.
- R7: Entering a live module's code region from another domain at any address other than its low code bound is a violation. Entry at the low bound is allowed.
- R8: An unprotect command frees the running module and forces both `cur_id_o` and `caller_id_o` to 0 on the next cycle. Both stay 0 afterwards while the program counter remains in the freed region.
- R9: An enable whose data region is not empty issues one clear write per cycle, starting on the next cycle. The addresses begin at the word-aligned low data bound and step by 2 while below the high bound. The module has no protection effect until the last clear write has gone out. An empty data region gives no clear writes and the module goes live at once.
- R10: `viol_irq_o` is set by a violation and stays set until a cycle in which `instr_done_i` is high and no new violation occurs.
- R11: `viol_o` is high for exactly the cycle that follows the offending inputs.
- R12: An enable that arrives while a clear is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | 16 | Current program counter |
| instr_done_i | input | 1 | Last cycle of the current instruction |
| mem_en_i | input | 1 | Data access valid |
| mem_we_i | input | 1 | Data access is a write |
| mem_addr_i | input | 16 | Data access byte address |
| enable_i | input | 1 | Enable a new module with the cfg bounds |
| unprotect_i | input | 1 | Running module gives up its protection |
| cfg_code_lo_i | input | 16 | New module code low bound |
| cfg_code_hi_i | input | 16 | New module code high bound (exclusive) |
| cfg_data_lo_i | input | 16 | New module data low bound |
| cfg_data_hi_i | input | 16 | New module data high bound (exclusive) |
| cur_id_o | output | 3 | ID of the executing domain |
| caller_id_o | output | 3 | ID of the domain executed before the last change |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_irq_o | output | 1 | Violation interrupt held to instruction end |
| clr_we_o | output | 1 | Clear write request |
| clr_addr_o | output | 16 | Clear write address |

## Verification
The assertions assume that `enable_i` and `unprotect_i` are single-cycle commands. They also assume that `instr_done_i` marks instruction boundaries and that configured spans do not wrap past the top of the address space. The stimulus raises each command for one cycle only. It picks bounds far below 0xFFFF and holds `instr_done_i` high outside the interrupt-hold scenario. That way every cycle counts as an instruction boundary, unless the scenario needs a longer instruction.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_CLEAR = 2'd1,
      SLOT_LIVE  = 2'd2
   } slot_state_e;

   typedef struct packed {
      logic code_write;
      logic data_foreign;
      logic bad_entry;
   } viol_cause_t;

endpackage

// File: rtl/pmac_range.sv
module pmac_range #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] lo_i,
   input  logic [AW-1:0] hi_i,
   input  logic [AW-1:0] addr_i,
   output logic          hit_o
);
   logic nonempty;

   always_comb begin
      nonempty = (lo_i < hi_i);
      hit_o    = nonempty && (addr_i >= lo_i) && (addr_i < hi_i);
   end

endmodule

// File: rtl/pmac_slot.sv
module pmac_slot
   import pmac_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          data_empty_i,
   input  logic          clear_done_i,
   input  logic          kill_i,
   input  logic [AW-1:0] code_lo_i,
   input  logic [AW-1:0] code_hi_i,
   input  logic [AW-1:0] data_lo_i,
   input  logic [AW-1:0] data_hi_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] mem_addr_i,
   output logic          free_o,
   output logic          clearing_o,
   output logic          live_o,
   output logic          pc_in_code_o,
   output logic          pc_at_start_o,
   output logic          mem_in_code_o,
   output logic          mem_in_data_o
);
   slot_state_e   state_q;
   logic [AW-1:0] code_lo_q, code_hi_q, data_lo_q, data_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SLOT_FREE;
         code_lo_q <= '0;
         code_hi_q <= '0;
         data_lo_q <= '0;
         data_hi_q <= '0;
      end else begin
         case (state_q)
            SLOT_FREE: begin
               if (load_i) begin
                  code_lo_q <= code_lo_i;
                  code_hi_q <= code_hi_i;
                  data_lo_q <= data_lo_i;
                  data_hi_q <= data_hi_i;
                  state_q   <= data_empty_i ? SLOT_LIVE : SLOT_CLEAR;
               end
            end
            SLOT_CLEAR: begin
               if (clear_done_i) state_q <= SLOT_LIVE;
            end
            SLOT_LIVE: begin
               if (kill_i) state_q <= SLOT_FREE;
            end
            default: state_q <= SLOT_FREE;
         endcase
      end
   end

   pmac_range #(.AW(AW)) u_pc_code (
      .lo_i(code_lo_q), .hi_i(code_hi_q), .addr_i(pc_i), .hit_o(pc_in_code_o)
   );
   pmac_range #(.AW(AW)) u_mem_code (
      .lo_i(code_lo_q), .hi_i(code_hi_q), .addr_i(mem_addr_i), .hit_o(mem_in_code_o)
   );
   pmac_range #(.AW(AW)) u_mem_data (
      .lo_i(data_lo_q), .hi_i(data_hi_q), .addr_i(mem_addr_i), .hit_o(mem_in_data_o)
   );

   always_comb begin
      free_o        = (state_q == SLOT_FREE);
      clearing_o    = (state_q == SLOT_CLEAR);
      live_o        = (state_q == SLOT_LIVE);
      pc_at_start_o = (pc_i == code_lo_q);
   end

   // R9: a slot only becomes live from clearing when the clear walk reports its end
   p_live_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_CLEAR) && !clear_done_i |=> (state_q == SLOT_CLEAR));

   // R8: a freed slot stays free until a new load arrives
   p_free_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_FREE) && !load_i |=> (state_q == SLOT_FREE));

endmodule

// File: rtl/pmac_clear_seq.sv
module pmac_clear_seq #(
   parameter int AW         = 16,
   parameter bit WORD_CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] lo_i,
   input  logic [AW-1:0] hi_i,
   output logic          busy_o,
   output logic          we_o,
   output logic [AW-1:0] addr_o,
   output logic          done_o
);
   localparam int STEP = WORD_CLEAR ? 2 : 1;

   logic          busy_q;
   logic [AW-1:0] addr_q, hi_q;
   logic [AW-1:0] start_addr;
   logic [AW:0]   next_addr;
   logic          last;

   generate
      if (WORD_CLEAR) begin : g_word
         assign start_addr = {lo_i[AW-1:1], 1'b0};
      end else begin : g_byte
         assign start_addr = lo_i;
      end
   endgenerate

   always_comb begin
      next_addr = {1'b0, addr_q} + (AW+1)'(STEP);
      last      = next_addr >= {1'b0, hi_q};
      done_o    = busy_q && last;
      busy_o    = busy_q;
      we_o      = busy_q;
      addr_o    = addr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         hi_q   <= '0;
      end else if (busy_q) begin
         if (last) busy_q <= 1'b0;
         else      addr_q <= next_addr[AW-1:0];
      end else if (start_i) begin
         busy_q <= 1'b1;
         addr_q <= start_addr;
         hi_q   <= hi_i;
      end
   end

   // R9: consecutive clear writes advance by exactly one step
   p_clear_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last |=> busy_q && (addr_q == $past(addr_q) + AW'(STEP)));

   // R9: every clear write targets an address below the high bound
   p_clear_below_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (addr_q < hi_q));

endmodule

// File: rtl/pmac_top.sv
module pmac_top
   import pmac_pkg::*;
#(
   parameter int NUM_MOD    = 4,
   parameter int AW         = 16,
   parameter bit WORD_CLEAR = 1'b1,
   parameter int ID_W       = $clog2(NUM_MOD + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   pc_i,
   input  logic            instr_done_i,
   input  logic            mem_en_i,
   input  logic            mem_we_i,
   input  logic [AW-1:0]   mem_addr_i,
   input  logic            enable_i,
   input  logic            unprotect_i,
   input  logic [AW-1:0]   cfg_code_lo_i,
   input  logic [AW-1:0]   cfg_code_hi_i,
   input  logic [AW-1:0]   cfg_data_lo_i,
   input  logic [AW-1:0]   cfg_data_hi_i,
   output logic [ID_W-1:0] cur_id_o,
   output logic [ID_W-1:0] caller_id_o,
   output logic            viol_o,
   output logic            viol_irq_o,
   output logic            clr_we_o,
   output logic [AW-1:0]   clr_addr_o
);
   generate
      if (NUM_MOD < 1 || NUM_MOD > 15) begin : g_bad_num_mod
         $error("pmac_top: NUM_MOD must lie in 1..15");
      end
      if (AW < 8) begin : g_bad_aw
         $error("pmac_top: AW must be at least 8");
      end
      if (ID_W < $clog2(NUM_MOD + 1)) begin : g_bad_idw
         $error("pmac_top: ID_W too narrow for NUM_MOD");
      end
   endgenerate

   logic [NUM_MOD-1:0] free_v, clearing_v, live_v;
   logic [NUM_MOD-1:0] pc_code_v, pc_start_v, mem_code_v, mem_data_v;
   logic [NUM_MOD-1:0] load_v, kill_v;

   logic            clr_busy, clr_done;
   logic            data_empty, load_ok;
   logic [ID_W-1:0] pc_dom;
   logic [ID_W-1:0] cur_id_q, caller_id_q;
   logic            viol_q, irq_q;
   viol_cause_t     cause;
   logic            viol_now;

   // ---------------- slot allocation ----------------
   always_comb begin
      data_empty = !(cfg_data_lo_i < cfg_data_hi_i);
      load_ok    = enable_i && !clr_busy;
      load_v     = '0;
      for (int k = NUM_MOD - 1; k >= 0; k--) begin
         if (free_v[k]) begin
            load_v    = '0;
            load_v[k] = load_ok;
         end
      end
   end

   always_comb begin
      for (int k = 0; k < NUM_MOD; k++) begin
         kill_v[k] = unprotect_i && live_v[k] && (cur_id_q == ID_W'(k + 1));
      end
   end

   generate
      for (genvar g = 0; g < NUM_MOD; g++) begin : g_slot
         pmac_slot #(.AW(AW)) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .load_i        (load_v[g]),
            .data_empty_i  (data_empty),
            .clear_done_i  (clr_done),
            .kill_i        (kill_v[g]),
            .code_lo_i     (cfg_code_lo_i),
            .code_hi_i     (cfg_code_hi_i),
            .data_lo_i     (cfg_data_lo_i),
            .data_hi_i     (cfg_data_hi_i),
            .pc_i          (pc_i),
            .mem_addr_i    (mem_addr_i),
            .free_o        (free_v[g]),
            .clearing_o    (clearing_v[g]),
            .live_o        (live_v[g]),
            .pc_in_code_o  (pc_code_v[g]),
            .pc_at_start_o (pc_start_v[g]),
            .mem_in_code_o (mem_code_v[g]),
            .mem_in_data_o (mem_data_v[g])
         );
      end
   endgenerate

   pmac_clear_seq #(.AW(AW), .WORD_CLEAR(WORD_CLEAR)) u_clear (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (|load_v && !data_empty),
      .lo_i    (cfg_data_lo_i),
      .hi_i    (cfg_data_hi_i),
      .busy_o  (clr_busy),
      .we_o    (clr_we_o),
      .addr_o  (clr_addr_o),
      .done_o  (clr_done)
   );

   // ---------------- domain resolution ----------------
   always_comb begin
      pc_dom = '0;
      for (int k = NUM_MOD - 1; k >= 0; k--) begin
         if (live_v[k] && pc_code_v[k]) pc_dom = ID_W'(k + 1);
      end
   end

   // ---------------- violation checks ----------------
   always_comb begin
      cause = '0;
      for (int k = 0; k < NUM_MOD; k++) begin
         if (live_v[k]) begin
            if (mem_en_i && mem_we_i && mem_code_v[k])
               cause.code_write = 1'b1;
            if (mem_en_i && mem_data_v[k] && (pc_dom != ID_W'(k + 1)))
               cause.data_foreign = 1'b1;
            if ((pc_dom == ID_W'(k + 1)) && (cur_id_q != ID_W'(k + 1)) && !pc_start_v[k])
               cause.bad_entry = 1'b1;
         end
      end
      viol_now = |cause;
   end

   // ---------------- registered state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_id_q    <= '0;
         caller_id_q <= '0;
      end else if (unprotect_i) begin
         cur_id_q    <= '0;
         caller_id_q <= '0;
      end else if (pc_dom != cur_id_q) begin
         caller_id_q <= cur_id_q;
         cur_id_q    <= pc_dom;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         viol_q <= viol_now;
         if (viol_now)          irq_q <= 1'b1;
         else if (instr_done_i) irq_q <= 1'b0;
      end
   end

   assign cur_id_o    = cur_id_q;
   assign caller_id_o = caller_id_q;
   assign viol_o      = viol_q;
   assign viol_irq_o  = irq_q;

   // ---------------- assertions ----------------
   // R8: unprotect leaves no stale caller or current ID
   p_unprot_zero_ids_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unprotect_i |=> (caller_id_o == '0) && (cur_id_o == '0));

   // R4: caller ID holds while the domain does not change
   p_caller_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_dom == cur_id_q) && !unprotect_i |=> $stable(caller_id_o));

   // R10: the pulse always comes with the latched interrupt
   p_pulse_sets_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> viol_irq_o);

   // R10: the interrupt cannot drop before an instruction boundary
   p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_irq_o && !instr_done_i |=> viol_irq_o);

   // R12: at most one slot is ever waiting for its clear walk
   p_single_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(clearing_v) <= 1);

   // R9: a clearing slot implies the clear walk is running
   p_clear_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|clearing_v) |-> clr_we_o);

   // R3: IDs reported never exceed the number of slots
   p_id_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_id_o <= ID_W'(NUM_MOD)) && (caller_id_o <= ID_W'(NUM_MOD)));

endmodule

// File: tb/pmac_top_tb.sv
`timescale 1ns/1ps
module pmac_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc = 16'h4000;
   logic        instr_done = 1'b1;
   logic        mem_en = 1'b0, mem_we = 1'b0;
   logic [15:0] mem_addr = 16'h0;
   logic        enable = 1'b0, unprotect = 1'b0;
   logic [15:0] c_lo = '0, c_hi = '0, d_lo = '0, d_hi = '0;
   logic [2:0]  cur_id, caller_id;
   logic        viol, irq, clr_we;
   logic [15:0] clr_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pmac_top u_dut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .instr_done_i(instr_done),
      .mem_en_i(mem_en), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
      .enable_i(enable), .unprotect_i(unprotect),
      .cfg_code_lo_i(c_lo), .cfg_code_hi_i(c_hi),
      .cfg_data_lo_i(d_lo), .cfg_data_hi_i(d_hi),
      .cur_id_o(cur_id), .caller_id_o(caller_id), .viol_o(viol),
      .viol_irq_o(irq), .clr_we_o(clr_we), .clr_addr_o(clr_addr)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic access(logic [15:0] a, logic w);
      mem_en = 1'b1; mem_we = w; mem_addr = a;
      tick();
      mem_en = 1'b0; mem_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cur", cur_id, 0);
      chk("R1 caller", caller_id, 0);
      chk("R1 viol", viol, 0);
      chk("R1 irq", irq, 0);
      chk("R1 clr", clr_we, 0);
   endtask

   task automatic t_enable_clear();
      c_lo = 16'h6000; c_hi = 16'h6100; d_lo = 16'h0200; d_hi = 16'h0208;
      enable = 1'b1; tick(); enable = 1'b0;
      chk("R9 clr first", {clr_we, clr_addr}, {1'b1, 16'h0200});
      // second enable during clear must be dropped (R12)
      c_lo = 16'h7000; c_hi = 16'h7100; d_lo = 16'h0300; d_hi = 16'h0304;
      enable = 1'b1; tick(); enable = 1'b0;
      chk("R9 clr second", {clr_we, clr_addr}, {1'b1, 16'h0202});
      pc = 16'h6050; tick();
      chk("R9 clr third", {clr_we, clr_addr}, {1'b1, 16'h0204});
      chk("R9 not usable yet", cur_id, 0);
      pc = 16'h4000; tick();
      chk("R9 clr fourth", {clr_we, clr_addr}, {1'b1, 16'h0206});
      tick();
      chk("R9 clr end", clr_we, 0);
      chk("R9 no viol during clear", viol, 0);
      pc = 16'h7004; tick();
      chk("R12 dropped enable", {viol, cur_id}, {1'b0, 3'd0});
      pc = 16'h4000; tick();
   endtask

   task automatic t_entry_and_irq();
      instr_done = 1'b0;
      pc = 16'h6002; tick();
      chk("R7 bad entry", viol, 1);
      chk("R10 irq set", irq, 1);
      chk("R3 cur id", cur_id, 1);
      tick();
      chk("R11 pulse one cycle", viol, 0);
      chk("R10 irq held", irq, 1);
      instr_done = 1'b1; tick();
      chk("R10 irq dropped", irq, 0);
      pc = 16'h4000; tick();
      chk("R4 caller on exit", {cur_id, caller_id}, {3'd0, 3'd1});
      pc = 16'h6000; tick();
      chk("R7 good entry", viol, 0);
      chk("R4 caller on entry", {cur_id, caller_id}, {3'd1, 3'd0});
      pc = 16'h6004; tick();
      chk("R4 caller stable", caller_id, 0);
   endtask

   task automatic t_inside_access();
      access(16'h0206, 1'b1);
      chk("R6 own data write", viol, 0);
      access(16'h6010, 1'b1);
      chk("R5 own code write", viol, 1);
      access(16'h6010, 1'b0);
      chk("R5 code read ok", viol, 0);
      access(16'h6100, 1'b1);
      chk("R2 code hi exclusive", viol, 0);
   endtask

   task automatic t_outside_access();
      pc = 16'h4000; tick();
      access(16'h0200, 1'b0);
      chk("R6 foreign read lo", viol, 1);
      access(16'h0207, 1'b1);
      chk("R6 foreign write", viol, 1);
      access(16'h0208, 1'b0);
      chk("R2 data hi exclusive", viol, 0);
      access(16'h01FF, 1'b1);
      chk("R2 below lo", viol, 0);
   endtask

   task automatic t_unprotect();
      pc = 16'h6000; tick();
      chk("R8 pre", cur_id, 1);
      pc = 16'h6004; unprotect = 1'b1; tick(); unprotect = 1'b0;
      chk("R8 ids zero", {cur_id, caller_id}, {3'd0, 3'd0});
      pc = 16'h6008; tick();
      chk("R8 ids stay zero", {cur_id, caller_id, viol}, {3'd0, 3'd0, 1'b0});
      pc = 16'h4000; tick();
      access(16'h0200, 1'b1);
      chk("R8 data released", viol, 0);
   endtask

   task automatic t_empty_and_ids();
      c_lo = 16'h5000; c_hi = 16'h5000; d_lo = 16'h0400; d_hi = 16'h0400;
      enable = 1'b1; tick(); enable = 1'b0;
      chk("R9 empty no clear", clr_we, 0);
      pc = 16'h5000; tick();
      chk("R2 empty code", {cur_id, viol}, {3'd0, 1'b0});
      pc = 16'h4000; tick();
      c_lo = 16'h6800; c_hi = 16'h6900; d_lo = 16'h0500; d_hi = 16'h0502;
      enable = 1'b1; tick(); enable = 1'b0;
      chk("R9 single clear", {clr_we, clr_addr}, {1'b1, 16'h0500});
      tick();
      chk("R9 single clear end", clr_we, 0);
      pc = 16'h6800; tick();
      chk("R3 second slot id", cur_id, 2);
      pc = 16'h4000; tick();
      chk("R4 caller two", caller_id, 2);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_enable_clear();
      t_entry_and_irq();
      t_inside_access();
      t_outside_access();
      t_unprotect();
      t_empty_and_ids();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule